// File: doc/BRIEF.md
# Interrupt Priority Level Gate

This block holds the processor's current interrupt priority level and decides whether a pending device request may interrupt the processor. A request is let through only when its priority is strictly above the current level. While a request is let through, the old level is offered on a save port so the core can push it onto its stack. When the core acknowledges, the current level is replaced by the level of the request.

The core also has two other ways to change the level. On return from an interrupt, a restore strobe brings back a popped level. A direct write port sets the level outright. When several of these fall in the same cycle, a fixed priority picks one of them. Stack storage, vector fetch and per-device priority registers sit outside this block.

Top module: `ipl_gate`

## Requirements
- R1: After reset `cur_level` is 0, and `accept` is 0 while `req_valid` is 0.
- R2: `accept` is 1 exactly when `req_valid` is 1, `restore_en` is 0, and `req_level` is strictly greater than `cur_level` (unsigned). If `req_level` is equal to or below `cur_level`, the request is held off.
- R3: While `accept` is 1, `save_level` equals `cur_level`. While `accept` is 0, `save_level` is 0.
- R4: If `accept` and `core_ack` are both 1 at a rising clock edge, `cur_level` equals the `req_level` of that edge from the next cycle on.
- R5: If `core_ack` is 1 while `accept` is 0, the level does not change because of it.
- R6: If `restore_en` is 1 at an edge, `cur_level` takes `restore_level` for the next cycle. This holds whatever `wr_en` and `core_ack` are doing, and the restore also holds `accept` at 0.
- R7: If `wr_en` is 1, `restore_en` is 0, and there is no accepted acknowledge, `cur_level` takes `wr_level` at the edge.
- R8: An accepted acknowledge wins over a direct write in the same cycle, so `wr_level` is dropped.
- R9: With no restore, no accepted acknowledge and no write, `cur_level` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A device request is pending |
| req_level | input | LVL_W | Priority of the pending request |
| core_ack | input | 1 | The core takes the accepted request this cycle |
| restore_en | input | 1 | Load the level from `restore_level` |
| restore_level | input | LVL_W | Level popped on interrupt return |
| wr_en | input | 1 | Direct write of the level |
| wr_level | input | LVL_W | Value for the direct write |
| cur_level | output | LVL_W | Current processor interrupt priority level |
| accept | output | 1 | The request beats the current level |
| save_level | output | LVL_W | Old level to push while `accept` is 1 |

## Verification
The sources that collide are the restore strobe, an accepted acknowledge and the direct write. All three can land on the same clock edge. Each may also meet a request that would otherwise be accepted.

The bench first sets every starting level with a write. It then drives every request level, with and without valid, against each on/off mix of acknowledge, restore and write. Restore and write values are kept different from each other and from the request level, so whichever source won can be read from `cur_level` one cycle later. A bench model computes the expected level and `accept` from the fixed priority order.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
    localparam int IPL_W_DEF = 3;

    typedef enum logic [1:0] {
        SRC_HOLD    = 2'd0,
        SRC_RESTORE = 2'd1,
        SRC_ACCEPT  = 2'd2,
        SRC_WRITE   = 2'd3
    } lvl_src_e;
endpackage

// File: rtl/ipl_cmp.sv
module ipl_cmp #(
    parameter int LVL_W = ipl_pkg::IPL_W_DEF
) (
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic             restore_en,
    input  logic [LVL_W-1:0] cur_level,
    output logic             accept,
    output logic [LVL_W-1:0] save_level
);
    logic higher;

    always_comb begin
        higher     = (req_level > cur_level);
        accept     = req_valid && !restore_en && higher;
        save_level = accept ? cur_level : '0;
    end
endmodule

// File: rtl/ipl_sel.sv
module ipl_sel #(
    parameter int LVL_W = ipl_pkg::IPL_W_DEF
) (
    input  logic                restore_en,
    input  logic [LVL_W-1:0]    restore_level,
    input  logic                take,
    input  logic [LVL_W-1:0]    req_level,
    input  logic                wr_en,
    input  logic [LVL_W-1:0]    wr_level,
    input  logic [LVL_W-1:0]    cur_level,
    output ipl_pkg::lvl_src_e   src,
    output logic [LVL_W-1:0]    next_level
);
    import ipl_pkg::*;

    always_comb begin
        if (restore_en)  src = SRC_RESTORE;
        else if (take)   src = SRC_ACCEPT;
        else if (wr_en)  src = SRC_WRITE;
        else             src = SRC_HOLD;

        unique case (src)
            SRC_RESTORE: next_level = restore_level;
            SRC_ACCEPT:  next_level = req_level;
            SRC_WRITE:   next_level = wr_level;
            default:     next_level = cur_level;
        endcase
    end
endmodule

// File: rtl/ipl_gate.sv
module ipl_gate #(
    parameter int LVL_W = ipl_pkg::IPL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic             core_ack,
    input  logic             restore_en,
    input  logic [LVL_W-1:0] restore_level,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_level,
    output logic [LVL_W-1:0] cur_level,
    output logic             accept,
    output logic [LVL_W-1:0] save_level
);
    typedef struct packed {
        logic [LVL_W-1:0] lvl;
    } gate_state_t;

    gate_state_t       state_d, state_q;
    ipl_pkg::lvl_src_e src;
    logic [LVL_W-1:0]  sel_level;
    logic              take;

    ipl_cmp #(.LVL_W(LVL_W)) u_cmp (
        .req_valid  (req_valid),
        .req_level  (req_level),
        .restore_en (restore_en),
        .cur_level  (state_q.lvl),
        .accept     (accept),
        .save_level (save_level)
    );

    assign take = accept && core_ack;

    ipl_sel #(.LVL_W(LVL_W)) u_sel (
        .restore_en    (restore_en),
        .restore_level (restore_level),
        .take          (take),
        .req_level     (req_level),
        .wr_en         (wr_en),
        .wr_level      (wr_level),
        .cur_level     (state_q.lvl),
        .src           (src),
        .next_level    (sel_level)
    );

    always_comb begin
        state_d     = state_q;
        state_d.lvl = sel_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cur_level = state_q.lvl;
endmodule

// File: rtl/ipl_gate_chk.sv
module ipl_gate_chk #(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LVL_W-1:0] req_level,
    input logic             core_ack,
    input logic             restore_en,
    input logic [LVL_W-1:0] restore_level,
    input logic             wr_en,
    input logic [LVL_W-1:0] wr_level,
    input logic [LVL_W-1:0] cur_level,
    input logic             accept,
    input logic [LVL_W-1:0] save_level
);
    a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_level <= cur_level) |-> !accept);

    a_r3_save_old: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (save_level == cur_level));

    a_r4_take_level: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && core_ack) |=> (cur_level == $past(req_level)));

    a_r6_restore: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> (cur_level == $past(restore_level)));

    a_r6_restore_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |-> !accept);

    a_r7_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restore_en && !(accept && core_ack)) |=> (cur_level == $past(wr_level)));

    a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && !wr_en && !(accept && core_ack)) |=> $stable(cur_level));
endmodule

bind ipl_gate ipl_gate_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .core_ack(core_ack), .restore_en(restore_en), .restore_level(restore_level),
    .wr_en(wr_en), .wr_level(wr_level), .cur_level(cur_level),
    .accept(accept), .save_level(save_level)
);

// File: tb/ipl_gate_bench.sv
module ipl_gate_bench;
    localparam int W = 3;
    localparam int NL = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, core_ack = 1'b0, restore_en = 1'b0, wr_en = 1'b0;
    logic [W-1:0] req_level = '0, restore_level = '0, wr_level = '0;
    logic [W-1:0] cur_level, save_level;
    logic         accept;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ipl_gate #(.LVL_W(W)) u_ipl_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .core_ack(core_ack), .restore_en(restore_en), .restore_level(restore_level),
        .wr_en(wr_en), .wr_level(wr_level), .cur_level(cur_level),
        .accept(accept), .save_level(save_level)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; core_ack = 0; restore_en = 0; wr_en = 0;
    endtask

    task automatic load(input int lvl);
        @(negedge clk);
        idle();
        wr_en = 1; wr_level = W'(lvl);
        @(negedge clk);
        idle();
        check("R7 direct write", int'(cur_level), lvl);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset level", int'(cur_level), 0);
        check("R1 reset accept", int'(accept), 0);
        rst_n = 1;
        @(negedge clk);
        check("R9 hold after reset", int'(cur_level), 0);

        for (int c = 0; c < NL; c++) begin
            for (int r = 0; r < NL; r++) begin
                for (int mix = 0; mix < 16; mix++) begin
                    int exp_acc, exp_lvl, rl, wl;
                    string tag;
                    load(c);
                    rl = (c + 3) % NL; wl = (c + 5) % NL;
                    if (rl == r) rl = (rl + 1) % NL;
                    if (wl == r || wl == rl) wl = (wl + 2) % NL;
                    if (wl == r || wl == rl) wl = (wl + 1) % NL;
                    req_valid  = mix[0];
                    core_ack   = mix[1];
                    restore_en = mix[2];
                    wr_en      = mix[3];
                    req_level  = W'(r);
                    restore_level = W'(rl);
                    wr_level   = W'(wl);
                    #1;
                    exp_acc = (mix[0] && !mix[2] && r > c) ? 1 : 0;
                    check(exp_acc ? "R2 accept" : "R2 held off", int'(accept), exp_acc);
                    check("R3 save level", int'(save_level), exp_acc ? c : 0);
                    if (mix[2])                   begin exp_lvl = rl; tag = "R6 restore wins"; end
                    else if (exp_acc && mix[1])   begin exp_lvl = r;
                                                        tag = mix[3] ? "R8 ack over write" : "R4 take level"; end
                    else if (mix[3])              begin exp_lvl = wl; tag = "R7 write"; end
                    else                          begin exp_lvl = c;
                                                        tag = mix[1] ? "R5 ack ignored" : "R9 keep"; end
                    @(negedge clk);
                    idle();
                    check(tag, int'(cur_level), exp_lvl);
                end
            end
        end

        load(6);
        rst_n = 0;
        #1;
        check("R1 async reset", int'(cur_level), 0);
        rst_n = 1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule